// File: doc/BRIEF.md
# Inverted Page Table Walker

This block turns a virtual page number, tagged with an address-space identifier, into a physical frame number. The lookup goes through an inverted page table, which holds one entry for each physical frame. A hash of the page number and the identifier selects a slot in a hash anchor table held in memory. That slot gives the index of the first table entry on a candidate chain. The walker reads the chain one entry at a time and compares each entry with the request. It stops when an entry matches, when the chain ends, or when it has read as many entries as there are frames.

The walker shares a single memory read port for the anchor table and the page table. The two tables start at base word addresses that come in as inputs. The memory returns each word one cycle after the read strobe. One request is in flight at a time. The answer is a one-cycle response with either a frame number or a page fault. On a hit, the frame number is the position of the matching entry in the table.

Top module: `ipt_walker`

## Requirements
- R1: While reset is held and after it is released, `reqReady` is 1, `rspValid` is 0 and `memRd` is 0.
- R2: The anchor index is an XOR fold of the request. Bit i of the VPN and bit j of the ASID are XORed into index bit (i mod HASH_W) and (j mod HASH_W). The first read after a request is accepted goes to address `hatBase + index`.
- R3: An anchor word whose pointer field, bits [FRAME_W:0], has its top bit set (all ones is the usual value) is an empty slot. The result is a page fault after exactly one memory read.
- R4: Entry k of the table sits at word `iptBase + k`. Its layout is: next pointer in bits [FRAME_W:0], ASID above that, VPN above the ASID, and the valid flag in the top bit.
- R5: An entry matches only when its valid flag is 1 and both its VPN and its ASID equal the request. A match gives `rspFault`=0 and `rspFrame` = the entry's index.
- R6: A non-matching entry passes control to its next pointer. A next pointer with its top bit set ends the chain, and the result is then a page fault with `rspFrame`=0.
- R7: When NUM_FRAMES entries have been read without a match, the walk stops with a page fault, even on a cyclic chain. A walk therefore makes at most NUM_FRAMES+1 reads.
- R8: Reads are never back to back, and no read is issued while `reqReady` is 1. `rspValid` is a one-cycle pulse, raised by the clock edge 2·N edges after the accepting edge, where N is the number of reads the walk made.
- R9: While a walk is running, `reqReady` is 0 and `reqValid` is ignored: the walk's result and read count are unchanged, and no extra response follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request strobe, taken when reqReady is 1 |
| reqVpn | input | VPN_W | Virtual page number to translate |
| reqAsid | input | ASID_W | Address-space identifier of the request |
| reqReady | output | 1 | Walker idle, a request is accepted |
| hatBase | input | ADDR_W | Word address of anchor table slot 0 |
| iptBase | input | ADDR_W | Word address of page table entry 0 |
| memRd | output | 1 | Memory read strobe |
| memAddr | output | ADDR_W | Memory word address |
| memRdata | input | DATA_W | Memory word, valid the cycle after memRd |
| rspValid | output | 1 | One-cycle response strobe |
| rspFault | output | 1 | Page fault on this response |
| rspFrame | output | FRAME_W | Frame number of a hit, 0 on a fault |

## Verification
The assertions assume that the memory returns the addressed word exactly one cycle after each read strobe. They also assume that the tables do not change during a walk. The bench memory model is a registered array that is filled before reset and left untouched while a walk runs. Requests are always presented at a falling edge and held for one cycle, and only once the previous response has come. The exception is the deliberate mid-walk request used to show that a busy walker ignores it.

// File: rtl/iptw_pkg.sv
package iptw_pkg;

  typedef struct packed {
    logic ldReq;
    logic selHat;
    logic memRd;
    logic ldPtrHat;
    logic ldPtrNext;
    logic clrCnt;
    logic incCnt;
    logic finishHit;
    logic finishFault;
  } ctrlStrobe_t;

  typedef struct packed {
    logic hatEnd;
    logic entMatch;
    logic nextEnd;
    logic cntLimit;
  } dpStatus_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HAT_RD,
    ST_HAT_CHK,
    ST_ENT_RD,
    ST_ENT_CHK
  } walkState_t;

endpackage

// File: rtl/iptw_hash.sv
module iptw_hash #(
  parameter int VPN_W  = 12,
  parameter int ASID_W = 4,
  parameter int HASH_W = 3
) (
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ASID_W-1:0] asid,
  output logic [HASH_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = 0; i < VPN_W; i++) begin
      idx[i % HASH_W] = idx[i % HASH_W] ^ vpn[i];
    end
    for (int j = 0; j < ASID_W; j++) begin
      idx[j % HASH_W] = idx[j % HASH_W] ^ asid[j];
    end
  end

endmodule

// File: rtl/iptw_datapath.sv
module iptw_datapath
  import iptw_pkg::*;
#(
  parameter int VPN_W   = 12,
  parameter int ASID_W  = 4,
  parameter int HASH_W  = 3,
  parameter int FRAME_W = 3,
  parameter int ADDR_W  = 8,
  localparam int PTR_W      = FRAME_W + 1,
  localparam int DATA_W     = 1 + VPN_W + ASID_W + PTR_W,
  localparam int CNT_W      = FRAME_W + 1,
  localparam int NUM_FRAMES = 1 << FRAME_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        ctrl,
  output dpStatus_t          status,
  input  logic [VPN_W-1:0]   reqVpn,
  input  logic [ASID_W-1:0]  reqAsid,
  input  logic [ADDR_W-1:0]  hatBase,
  input  logic [ADDR_W-1:0]  iptBase,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic [DATA_W-1:0]  memRdata,
  output logic               rspValid,
  output logic               rspFault,
  output logic [FRAME_W-1:0] rspFrame
);

  localparam int ASID_LSB  = PTR_W;
  localparam int VPN_LSB   = PTR_W + ASID_W;
  localparam int VALID_BIT = DATA_W - 1;

  logic [VPN_W-1:0]   vpnQ;
  logic [ASID_W-1:0]  asidQ;
  logic [FRAME_W-1:0] ptrQ;
  logic [CNT_W-1:0]   cntQ;
  logic [HASH_W-1:0]  hashIdx;

  logic [PTR_W-1:0]   entNext;
  logic [ASID_W-1:0]  entAsid;
  logic [VPN_W-1:0]   entVpn;
  logic               entValid;

  iptw_hash #(.VPN_W(VPN_W), .ASID_W(ASID_W), .HASH_W(HASH_W)) uHash (
    .vpn (vpnQ),
    .asid(asidQ),
    .idx (hashIdx)
  );

  assign entNext  = memRdata[PTR_W-1:0];
  assign entAsid  = memRdata[ASID_LSB +: ASID_W];
  assign entVpn   = memRdata[VPN_LSB +: VPN_W];
  assign entValid = memRdata[VALID_BIT];

  always_comb begin
    if (ctrl.selHat) memAddr = hatBase + ADDR_W'(hashIdx);
    else             memAddr = iptBase + ADDR_W'(ptrQ);
  end

  always_comb begin
    status.hatEnd   = entNext[PTR_W-1];
    status.entMatch = entValid && (entVpn == vpnQ) && (entAsid == asidQ);
    status.nextEnd  = entNext[PTR_W-1];
    status.cntLimit = (cntQ == CNT_W'(NUM_FRAMES));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ     <= '0;
      asidQ    <= '0;
      ptrQ     <= '0;
      cntQ     <= '0;
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspFrame <= '0;
    end else begin
      if (ctrl.ldReq) begin
        vpnQ  <= reqVpn;
        asidQ <= reqAsid;
      end
      if (ctrl.ldPtrHat || ctrl.ldPtrNext) ptrQ <= entNext[FRAME_W-1:0];
      if (ctrl.clrCnt)      cntQ <= '0;
      else if (ctrl.incCnt) cntQ <= cntQ + 1'b1;
      rspValid <= ctrl.finishHit || ctrl.finishFault;
      if (ctrl.finishHit) begin
        rspFault <= 1'b0;
        rspFrame <= ptrQ;
      end else if (ctrl.finishFault) begin
        rspFault <= 1'b1;
        rspFrame <= '0;
      end
    end
  end

endmodule

// File: rtl/iptw_control.sv
module iptw_control
  import iptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  dpStatus_t   status,
  output ctrlStrobe_t ctrl
);

  walkState_t stateQ, stateD;

  always_comb begin
    ctrl     = '0;
    stateD   = stateQ;
    reqReady = (stateQ == ST_IDLE);
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          ctrl.ldReq  = 1'b1;
          ctrl.clrCnt = 1'b1;
          stateD      = ST_HAT_RD;
        end
      end
      ST_HAT_RD: begin
        ctrl.memRd  = 1'b1;
        ctrl.selHat = 1'b1;
        stateD      = ST_HAT_CHK;
      end
      ST_HAT_CHK: begin
        if (status.hatEnd) begin
          ctrl.finishFault = 1'b1;
          stateD           = ST_IDLE;
        end else begin
          ctrl.ldPtrHat = 1'b1;
          stateD        = ST_ENT_RD;
        end
      end
      ST_ENT_RD: begin
        ctrl.memRd  = 1'b1;
        ctrl.incCnt = 1'b1;
        stateD      = ST_ENT_CHK;
      end
      ST_ENT_CHK: begin
        if (status.entMatch) begin
          ctrl.finishHit = 1'b1;
          stateD         = ST_IDLE;
        end else if (status.nextEnd || status.cntLimit) begin
          ctrl.finishFault = 1'b1;
          stateD           = ST_IDLE;
        end else begin
          ctrl.ldPtrNext = 1'b1;
          stateD         = ST_ENT_RD;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
  import iptw_pkg::*;
#(
  parameter int VPN_W   = 12,
  parameter int ASID_W  = 4,
  parameter int HASH_W  = 3,
  parameter int FRAME_W = 3,
  parameter int ADDR_W  = 8,
  localparam int PTR_W  = FRAME_W + 1,
  localparam int DATA_W = 1 + VPN_W + ASID_W + PTR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [VPN_W-1:0]   reqVpn,
  input  logic [ASID_W-1:0]  reqAsid,
  output logic               reqReady,
  input  logic [ADDR_W-1:0]  hatBase,
  input  logic [ADDR_W-1:0]  iptBase,
  output logic               memRd,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic [DATA_W-1:0]  memRdata,
  output logic               rspValid,
  output logic               rspFault,
  output logic [FRAME_W-1:0] rspFrame
);

  ctrlStrobe_t ctrl;
  dpStatus_t   status;

  iptw_control uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .status  (status),
    .ctrl    (ctrl)
  );

  iptw_datapath #(
    .VPN_W(VPN_W), .ASID_W(ASID_W), .HASH_W(HASH_W),
    .FRAME_W(FRAME_W), .ADDR_W(ADDR_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .status  (status),
    .reqVpn  (reqVpn),
    .reqAsid (reqAsid),
    .hatBase (hatBase),
    .iptBase (iptBase),
    .memAddr (memAddr),
    .memRdata(memRdata),
    .rspValid(rspValid),
    .rspFault(rspFault),
    .rspFrame(rspFrame)
  );

  assign memRd = ctrl.memRd;

endmodule

// File: rtl/ipt_walker_chk.sv
module ipt_walker_chk #(
  parameter int FRAME_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic               memRd,
  input logic               rspValid,
  input logic               rspFault,
  input logic [FRAME_W-1:0] rspFrame
);

  p_accept_hat_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> memRd);

  p_fault_frame_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> rspFrame == '0);

  p_no_read_when_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> !reqReady);

  p_read_spacing_r8: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> !memRd);

  p_resp_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_resp_when_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> reqReady);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> reqReady && !memRd && !rspValid);

endmodule

bind ipt_walker ipt_walker_chk #(.FRAME_W(FRAME_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .memRd   (memRd),
  .rspValid(rspValid),
  .rspFault(rspFault),
  .rspFrame(rspFrame)
);

// File: tb/tb_ipt_walker.sv
`timescale 1ns/1ps
module tb_ipt_walker;

  localparam int VPN_W = 12, ASID_W = 4, HASH_W = 3, FRAME_W = 3, ADDR_W = 8;
  localparam int PTR_W = FRAME_W + 1;
  localparam int DATA_W = 1 + VPN_W + ASID_W + PTR_W;
  localparam logic [ADDR_W-1:0] HAT_BASE = 8'h00;
  localparam logic [ADDR_W-1:0] IPT_BASE = 8'h10;

  typedef struct packed {
    logic [11:0] vpn;
    logic [3:0]  asid;
    logic        fault;
    logic [2:0]  frame;
    logic [7:0]  reads;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{12'h008, 4'h0, 1'b0, 3'd7, 8'd2},
    '{12'h049, 4'h0, 1'b0, 3'd5, 8'd3},
    '{12'h001, 4'h0, 1'b0, 3'd2, 8'd4},
    '{12'h008, 4'h9, 1'b1, 3'd0, 8'd4},
    '{12'h004, 4'h0, 1'b1, 3'd0, 8'd1},
    '{12'h123, 4'h3, 1'b0, 3'd0, 8'd2},
    '{12'h002, 4'h0, 1'b0, 3'd1, 8'd3},
    '{12'h010, 4'h0, 1'b1, 3'd0, 8'd3}
  };

  logic clk = 0, rstN = 0;
  logic reqValid = 0;
  logic [VPN_W-1:0] reqVpn = '0;
  logic [ASID_W-1:0] reqAsid = '0;
  logic reqReady, memRd, rspValid, rspFault;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memRdata;
  logic [FRAME_W-1:0] rspFrame;

  logic [DATA_W-1:0] mem [256];
  logic [ADDR_W-1:0] addrLog [256];
  int rdCount = 0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  ipt_walker dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVpn(reqVpn), .reqAsid(reqAsid),
    .reqReady(reqReady), .hatBase(HAT_BASE), .iptBase(IPT_BASE), .memRd(memRd),
    .memAddr(memAddr), .memRdata(memRdata), .rspValid(rspValid), .rspFault(rspFault),
    .rspFrame(rspFrame)
  );

  always @(posedge clk) begin
    if (memRd) begin
      memRdata <= mem[memAddr];
      addrLog[rdCount & 255] <= memAddr;
      rdCount <= rdCount + 1;
    end
  end

  function automatic logic [HASH_W-1:0] benchHash(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
    logic [HASH_W-1:0] h = '0;
    for (int i = 0; i < VPN_W; i++) h[i % HASH_W] ^= v[i];
    for (int j = 0; j < ASID_W; j++) h[j % HASH_W] ^= a[j];
    return h;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic putEntry(input int frame, input logic valid, input logic [VPN_W-1:0] v,
                          input logic [ASID_W-1:0] a, input logic [PTR_W-1:0] nxt);
    mem[IPT_BASE + frame] = {valid, v, a, nxt};
  endtask

  task automatic lookup(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                        output logic f, output logic [FRAME_W-1:0] fr,
                        output int reads, output int lat, output int startIdx);
    @(negedge clk);
    reqVpn = v; reqAsid = a; reqValid = 1'b1;
    startIdx = rdCount;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!rspValid && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    f = rspFault; fr = rspFrame;
    reads = rdCount - startIdx;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic f;
    logic [FRAME_W-1:0] fr;
    int reads, lat, s;

    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 8; i++) mem[HAT_BASE + i] = DATA_W'(4'hF);
    // chain on slot 1: 7 -> 5 -> 2
    mem[HAT_BASE + 1] = DATA_W'(4'd7);
    putEntry(7, 1'b1, 12'h008, 4'h0, 4'd5);
    putEntry(5, 1'b1, 12'h049, 4'h0, 4'd2);
    putEntry(2, 1'b1, 12'h001, 4'h0, 4'hF);
    // slot 0: single entry 0
    mem[HAT_BASE + 0] = DATA_W'(4'd0);
    putEntry(0, 1'b1, 12'h123, 4'h3, 4'hF);
    // slot 2: invalid entry 3 -> 1
    mem[HAT_BASE + 2] = DATA_W'(4'd3);
    putEntry(3, 1'b0, 12'h010, 4'h0, 4'd1);
    putEntry(1, 1'b1, 12'h002, 4'h0, 4'hF);
    // slot 6: cyclic chain 4 <-> 6
    mem[HAT_BASE + 6] = DATA_W'(4'd4);
    putEntry(4, 1'b1, 12'h7FF, 4'h0, 4'd6);
    putEntry(6, 1'b1, 12'h7FF, 4'h0, 4'd4);

    repeat (3) @(negedge clk);
    chk("R1", "reqReady in reset", 32'(reqReady), 32'd1);
    chk("R1", "rspValid in reset", 32'(rspValid), 32'd0);
    chk("R1", "memRd in reset", 32'(memRd), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "reqReady after reset", 32'(reqReady), 32'd1);
    chk("R1", "memRd after reset", 32'(memRd), 32'd0);

    // table walk: R2 R3 R4 R5 R6 R8
    foreach (VECS[k]) begin
      lookup(VECS[k].vpn, VECS[k].asid, f, fr, reads, lat, s);
      chk("R5 R6 R3", $sformatf("vec%0d fault", k), 32'(f), 32'(VECS[k].fault));
      chk("R5 R6", $sformatf("vec%0d frame", k), 32'(fr), 32'(VECS[k].frame));
      chk("R6 R3", $sformatf("vec%0d reads", k), 32'(reads), 32'(VECS[k].reads));
      chk("R8", $sformatf("vec%0d latency", k), 32'(lat), 32'(2 * VECS[k].reads + 1));
      chk("R2", $sformatf("vec%0d anchor addr", k), 32'(addrLog[s & 255]),
          32'(HAT_BASE + ADDR_W'(benchHash(VECS[k].vpn, VECS[k].asid))));
      if (!VECS[k].fault)
        chk("R4", $sformatf("vec%0d entry addr", k), 32'(addrLog[(s + reads - 1) & 255]),
            32'(IPT_BASE + ADDR_W'(VECS[k].frame)));
      @(negedge clk);
      chk("R8", $sformatf("vec%0d pulse end", k), 32'(rspValid), 32'd0);
    end

    // R7: cyclic chain stopped by walk limit
    lookup(12'h006, 4'h0, f, fr, reads, lat, s);
    chk("R7", "cyclic fault", 32'(f), 32'd1);
    chk("R7", "cyclic reads", 32'(reads), 32'd9);
    chk("R7", "cyclic latency", 32'(lat), 32'd19);

    // R9: request during walk is ignored
    @(negedge clk);
    reqVpn = 12'h008; reqAsid = 4'h9; reqValid = 1'b1;
    s = rdCount;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    chk("R9", "busy reqReady", 32'(reqReady), 32'd0);
    reqVpn = 12'h008; reqAsid = 4'h0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 3;
    while (!rspValid && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    chk("R9", "busy fault kept", 32'(rspFault), 32'd1);
    chk("R9", "busy reads", 32'(rdCount - s), 32'd4);
    reads = 0;
    repeat (12) begin
      @(negedge clk);
      if (rspValid) reads++;
    end
    chk("R9", "no extra response", 32'(reads), 32'd0);
    chk("R9", "no extra reads", 32'(rdCount - s), 32'd4);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule